// File: doc/BRIEF.md
# Wake-on-LAN Event Detector

This block watches the receive byte stream and the link indication of an Ethernet port while the host keeps the port in a low-power state. It recognises a fixed set of wake conditions: a frame sent to the station's own address, a multicast frame, a broadcast ARP request (plain or VLAN-tagged), any good frame, a Magic Packet, and a change of link state. When one of these conditions is enabled and occurs, the block latches a wake cause and raises a power-management event.

Wake status is held in two copies, one for the power-management register and one for the device control/status register. Both are set whenever an enabled wake event occurs, whether or not the event pin is enabled. The active-low event pin is pulled low only while status is set and the event enable is on. Software clears all status with a single write-one strobe.

Frame conditions are evaluated as the bytes arrive. They take effect only on the last byte of a frame whose CRC was reported good, so a corrupted frame never wakes the system.

Top module: `wol_event_detector`

## Requirements
- R1: After reset, `wake_cause_o` is 0, both status flags are 0 and `pme_n_o` is 1.
- R2: A good frame whose six destination bytes equal `station_mac_i` (bits 47:40 are the first byte on the wire) sets cause bit 0 when `wake_en_i[0]` is set.
- R3: A good frame whose first destination byte has bit 0 set, and whose destination is not all ones, sets cause bit 1 when `wake_en_i[1]` is set.
- R4: A good frame sent to FF:FF:FF:FF:FF:FF sets cause bit 2 when `wake_en_i[2]` is set, but only if it is an ARP frame. That means bytes 12–13 are 0x0806, or bytes 12–13 are 0x8100 and bytes 16–17 are 0x0806. A broadcast frame of any other type sets no bit unless the any-frame source is enabled.
- R5: Any good frame sets cause bit 3 when `wake_en_i[3]` is set.
- R6: A good frame that contains six 0xFF bytes followed at once by sixteen back-to-back copies of the station address sets cause bit 4 when `wake_en_i[4]` is set. A mismatch restarts the search, and a 0xFF byte at the point of mismatch counts as the first byte of a new sync run.
- R7: A change of `link_up_i` in either direction sets cause bit 5 when `wake_en_i[5]` is set. The first value sampled after reset is not counted as a change.
- R8: Frame events are committed only on the beat where `rx_valid_i`, `rx_eof_i` and `rx_crc_ok_i` are all high. The result is visible in the cycle after that beat. A frame that ends with a bad CRC changes nothing.
- R9: A source whose enable bit is clear never sets its cause bit. No event of any kind is recorded while `pwr_state_i` is 0 (D0). Events are recorded in states 1 to 3 (D1–D3).
- R10: Every recorded event sets both `pme_sts_pm_o` and `pme_sts_csr_o`, whatever the value of `pme_en_i`. Cause and status bits are sticky.
- R11: `pme_n_o` is low exactly when status is set and `pme_en_i` is high. This holds in every power state, including D0.
- R12: A pulse on `sts_clr_i` clears the cause bits and both status flags in the next cycle, which also releases `pme_n_o`. An event in the same cycle as the clear wins and remains recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_crc_ok_i | input | 1 | CRC good, qualified by the last byte |
| link_up_i | input | 1 | Synchronous PHY link state |
| station_mac_i | input | 48 | Station address, first wire byte in bits 47:40 |
| wake_en_i | input | 6 | Per-source wake enables (0 unicast, 1 multicast, 2 broadcast ARP, 3 any, 4 magic, 5 link) |
| pme_en_i | input | 1 | Event pin enable |
| pwr_state_i | input | 2 | Power state, 0 = D0 through 3 = D3 |
| sts_clr_i | input | 1 | Write-one strobe that clears all status |
| wake_cause_o | output | 6 | Sticky per-source wake cause |
| pme_sts_pm_o | output | 1 | Wake status, power-management copy |
| pme_sts_csr_o | output | 1 | Wake status, control/status copy |
| pme_n_o | output | 1 | Power-management event pin, active low |

## Verification
The bench sends broadcast frames of a non-ARP type with the any-frame source off. A design that decoded only the destination would wake on these. It also sends a VLAN-tagged ARP frame, which a design that read only bytes 12–13 would miss. One Magic Packet frame holds a false start that breaks on a 0xFF byte, with the real pattern beginning right at that byte. A search that discarded the mismatching byte would then count only five sync bytes and never match. Further cases cover a unicast frame with a bad CRC, events in D0, status raised with the pin disabled and then enabled in D0, and a clear that coincides with a link toggle; each catches a design that gates or orders these wrongly.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int N_SRC   = 6;
  localparam int SRC_UC  = 0;
  localparam int SRC_MC  = 1;
  localparam int SRC_ARP = 2;
  localparam int SRC_ANY = 3;
  localparam int SRC_MAG = 4;
  localparam int SRC_LNK = 5;
  localparam logic [15:0] ETYPE_ARP  = 16'h0806;
  localparam logic [15:0] ETYPE_VLAN = 16'h8100;
  typedef logic [N_SRC-1:0] wake_vec_t;
endpackage

// File: rtl/wol_frame_filter.sv
module wol_frame_filter #(
  parameter int MAC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             sof_i,
  input  logic [7:0]       byte_i,
  input  logic [MAC_W-1:0] mac_i,
  output logic             ucast_o,
  output logic             mcast_o,
  output logic             bcast_arp_o
);
  import wol_pkg::*;
  localparam int MAC_BYTES = MAC_W / 8;
  localparam int SEL_W     = $clog2(MAC_BYTES);
  localparam int TYPE_AT   = 2 * MAC_BYTES;
  localparam int VTYPE_AT  = TYPE_AT + 4;
  localparam int IDX_W     = $clog2(VTYPE_AT + 2) + 1;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [7:0]       mac_b [MAC_BYTES];
  logic [IDX_W-1:0] idx_q, cur;
  logic             uc_q, ff_q, mc_q, base_uc, base_ff;
  logic [15:0]      et0_q, et1_q;
  logic             hdr_done;

  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac
    assign mac_b[g] = mac_i[MAC_W-1-8*g -: 8];
  end

  assign cur     = sof_i ? '0 : idx_q;
  assign base_uc = sof_i ? 1'b1 : uc_q;
  assign base_ff = sof_i ? 1'b1 : ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      uc_q  <= 1'b0;
      ff_q  <= 1'b0;
      mc_q  <= 1'b0;
      et0_q <= '0;
      et1_q <= '0;
    end else if (vld_i) begin
      idx_q <= (cur == IDX_MAX) ? cur : cur + 1'b1;
      if (cur < IDX_W'(MAC_BYTES)) begin
        uc_q <= base_uc & (byte_i == mac_b[cur[SEL_W-1:0]]);
        ff_q <= base_ff & (byte_i == 8'hFF);
      end
      if (cur == '0) mc_q <= byte_i[0];
      if (sof_i) begin
        et0_q <= '0;
        et1_q <= '0;
      end
      if (cur == IDX_W'(TYPE_AT))      et0_q[15:8] <= byte_i;
      if (cur == IDX_W'(TYPE_AT + 1))  et0_q[7:0]  <= byte_i;
      if (cur == IDX_W'(VTYPE_AT))     et1_q[15:8] <= byte_i;
      if (cur == IDX_W'(VTYPE_AT + 1)) et1_q[7:0]  <= byte_i;
    end
  end

  assign hdr_done    = idx_q >= IDX_W'(MAC_BYTES);
  assign ucast_o     = hdr_done & uc_q;
  assign mcast_o     = hdr_done & mc_q & ~ff_q;
  assign bcast_arp_o = hdr_done & ff_q &
                       ((et0_q == ETYPE_ARP) || (et0_q == ETYPE_VLAN && et1_q == ETYPE_ARP));

  // R3
  mcast_not_bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mcast_o && bcast_arp_o));
endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect #(
  parameter int MAC_W = 48,
  parameter int SYNC  = 6,
  parameter int REPS  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             sof_i,
  input  logic [7:0]       byte_i,
  input  logic [MAC_W-1:0] mac_i,
  output logic             found_o
);
  localparam int MAC_BYTES = MAC_W / 8;
  localparam int SEL_W     = $clog2(MAC_BYTES);
  localparam int SYN_W     = $clog2(SYNC + 1);
  localparam int REP_W     = $clog2(REPS);

  logic [7:0]       mac_b [MAC_BYTES];
  logic [SYN_W-1:0] sync_q, sync_d, base_sync;
  logic [SEL_W-1:0] pos_q, pos_d, base_pos;
  logic [REP_W-1:0] rep_q, rep_d, base_rep;
  logic             found_q, found_d, base_found;
  logic             is_ff, hit, last;

  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac
    assign mac_b[g] = mac_i[MAC_W-1-8*g -: 8];
  end

  assign base_sync  = sof_i ? '0 : sync_q;
  assign base_pos   = sof_i ? '0 : pos_q;
  assign base_rep   = sof_i ? '0 : rep_q;
  assign base_found = sof_i ? 1'b0 : found_q;
  assign is_ff      = byte_i == 8'hFF;
  assign hit        = byte_i == mac_b[base_pos];
  assign last       = (base_pos == SEL_W'(MAC_BYTES - 1)) && (base_rep == REP_W'(REPS - 1));

  always_comb begin
    sync_d  = sync_q;
    pos_d   = pos_q;
    rep_d   = rep_q;
    found_d = found_q;
    if (vld_i) begin
      sync_d  = base_sync;
      pos_d   = base_pos;
      rep_d   = base_rep;
      found_d = base_found;
      if (base_sync < SYN_W'(SYNC)) begin
        sync_d = is_ff ? base_sync + 1'b1 : '0;
        pos_d  = '0;
        rep_d  = '0;
      end else if (hit) begin
        if (last) begin
          found_d = 1'b1;
          sync_d  = '0;
          pos_d   = '0;
          rep_d   = '0;
        end else if (base_pos == SEL_W'(MAC_BYTES - 1)) begin
          pos_d = '0;
          rep_d = base_rep + 1'b1;
        end else begin
          pos_d = base_pos + 1'b1;
        end
      end else if (is_ff && base_pos == '0 && base_rep == '0) begin
        sync_d = base_sync;  // extra sync byte
      end else begin
        // mismatch: an 0xFF here opens a new sync run
        sync_d = is_ff ? SYN_W'(1) : '0;
        pos_d  = '0;
        rep_d  = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      pos_q   <= '0;
      rep_q   <= '0;
      found_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      pos_q   <= pos_d;
      rep_q   <= rep_d;
      found_q <= found_d;
    end
  end

  assign found_o = found_d;

  // R6
  magic_pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q < SEL_W'(MAC_BYTES)) && (sync_q <= SYN_W'(SYNC)));
  // R6
  magic_sof_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sof_i) |=> !found_q);
endmodule

// File: rtl/wol_link_watch.sv
module wol_link_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_i,
  output logic change_o
);
  logic link_q, primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      link_q   <= link_i;
      primed_q <= 1'b1;
    end
  end

  assign change_o = primed_q & (link_i ^ link_q);

  // R7
  link_first_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_q |-> !change_o);
endmodule

// File: rtl/wol_event_detector.sv
module wol_event_detector #(
  parameter int MAC_W = 48,
  parameter int SYNC  = 6,
  parameter int REPS  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_sof_i,
  input  logic             rx_eof_i,
  input  logic             rx_crc_ok_i,
  input  logic             link_up_i,
  input  logic [MAC_W-1:0] station_mac_i,
  input  logic [5:0]       wake_en_i,
  input  logic             pme_en_i,
  input  logic [1:0]       pwr_state_i,
  input  logic             sts_clr_i,
  output logic [5:0]       wake_cause_o,
  output logic             pme_sts_pm_o,
  output logic             pme_sts_csr_o,
  output logic             pme_n_o
);
  import wol_pkg::*;

  logic      ucast, mcast, bcast_arp, magic, link_chg;
  logic      frame_ok, armed;
  wake_vec_t hits, evt, cause_q;
  logic      pm_sts_q, csr_sts_q;

  wol_frame_filter #(.MAC_W(MAC_W)) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(rx_valid_i), .sof_i(rx_sof_i),
    .byte_i(rx_data_i), .mac_i(station_mac_i),
    .ucast_o(ucast), .mcast_o(mcast), .bcast_arp_o(bcast_arp)
  );

  wol_magic_detect #(.MAC_W(MAC_W), .SYNC(SYNC), .REPS(REPS)) u_magic (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(rx_valid_i), .sof_i(rx_sof_i),
    .byte_i(rx_data_i), .mac_i(station_mac_i), .found_o(magic)
  );

  wol_link_watch u_link (
    .clk_i(clk_i), .rst_ni(rst_ni), .link_i(link_up_i), .change_o(link_chg)
  );

  assign frame_ok = rx_valid_i & rx_eof_i & rx_crc_ok_i;
  assign armed    = pwr_state_i != 2'd0;

  always_comb begin
    hits          = '0;
    hits[SRC_UC]  = frame_ok & ucast;
    hits[SRC_MC]  = frame_ok & mcast;
    hits[SRC_ARP] = frame_ok & bcast_arp;
    hits[SRC_ANY] = frame_ok;
    hits[SRC_MAG] = frame_ok & magic;
    hits[SRC_LNK] = link_chg;
    evt           = armed ? (hits & wake_en_i) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q   <= '0;
      pm_sts_q  <= 1'b0;
      csr_sts_q <= 1'b0;
    end else begin
      cause_q   <= (sts_clr_i ? '0 : cause_q) | evt;
      pm_sts_q  <= (sts_clr_i ? 1'b0 : pm_sts_q) | (|evt);
      csr_sts_q <= (sts_clr_i ? 1'b0 : csr_sts_q) | (|evt);
    end
  end

  assign wake_cause_o  = cause_q;
  assign pme_sts_pm_o  = pm_sts_q;
  assign pme_sts_csr_o = csr_sts_q;
  assign pme_n_o       = ~(pm_sts_q & pme_en_i);

  // R10
  sts_copies_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_sts_q == csr_sts_q);
  // R10
  cause_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_clr_i |=> ((cause_q & ~$past(cause_q)) | cause_q) == cause_q && ($past(cause_q) & ~cause_q) == '0);
  // R12
  clear_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr_i && !link_chg && !(rx_valid_i && rx_eof_i)) |=> (pme_n_o && cause_q == '0));
  // R8
  bad_crc_no_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_eof_i && !rx_crc_ok_i && !link_chg && !sts_clr_i) |=> $stable(cause_q));
  // R9
  d0_no_record_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_i == 2'd0 && !sts_clr_i) |=> $stable(cause_q));
  // R9
  disabled_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cause_q & ~$past(cause_q) & ~$past(wake_en_i)) == '0);
endmodule

// File: tb/sim_wol_event_detector.sv
`timescale 1ns/1ps
module sim_wol_event_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc = 0;
  logic [7:0]  rx_data = 0;
  logic        link = 0;
  logic [47:0] mac = 48'h001B2C3D4E5A;
  logic [5:0]  wake_en = 6'b110111;
  logic        pme_en = 1'b1;
  logic [1:0]  pwr = 2'd3;
  logic        clr = 1'b0;
  logic [5:0]  cause;
  logic        sts_pm, sts_csr, pme_n;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  wol_event_detector u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_crc_ok_i(rx_crc), .link_up_i(link),
    .station_mac_i(mac), .wake_en_i(wake_en), .pme_en_i(pme_en), .pwr_state_i(pwr),
    .sts_clr_i(clr), .wake_cause_o(cause), .pme_sts_pm_o(sts_pm),
    .pme_sts_csr_o(sts_csr), .pme_n_o(pme_n)
  );

  always #5 clk = ~clk;

  // reference model
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  logic [5:0] m_cause = 0;
  bit m_sts = 0, m_prev = 0, m_primed = 0;

  function automatic bit has_magic();
    int n = rxq.size();
    for (int p = 0; p + 102 <= n; p++) begin
      bit ok = 1;
      for (int k = 0; k < 6; k++) if (rxq[p+k] != 8'hFF) ok = 0;
      for (int k = 0; k < 96; k++) if (rxq[p+6+k] != mac[47-8*(k%6) -: 8]) ok = 0;
      if (ok) return 1;
    end
    return 0;
  endfunction

  function automatic logic [5:0] eval_frame();
    logic [5:0] e = 6'b001000;
    bit uc = 1, bc = 1, arp;
    for (int k = 0; k < 6; k++) begin
      if (rxq[k] != mac[47-8*k -: 8]) uc = 0;
      if (rxq[k] != 8'hFF) bc = 0;
    end
    arp = ({rxq[12], rxq[13]} == 16'h0806) ||
          ({rxq[12], rxq[13]} == 16'h8100 && {rxq[16], rxq[17]} == 16'h0806);
    e[0] = uc;
    e[1] = rxq[0][0] && !bc;
    e[2] = bc && arp;
    e[4] = has_magic();
    return e;
  endfunction

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    logic [5:0] evt;
    cyc++;
    if (!rst_n) begin
      m_cause = 0; m_sts = 0; m_prev = 0; m_primed = 0;
      rxq.delete();
    end else begin
      evt = 0;
      if (rx_valid) begin
        if (rx_sof) rxq.delete();
        rxq.push_back(rx_data);
        if (rx_eof && rx_crc && rxq.size() >= 18) evt = eval_frame();
      end
      if (m_primed && link != m_prev) evt[5] = 1;
      m_prev = link; m_primed = 1;
      evt &= wake_en;
      if (pwr == 2'd0) evt = 0;
      if (clr) begin m_cause = 0; m_sts = 0; end
      m_cause |= evt;
      if (|evt) m_sts = 1;
    end
    #2;
    if (!done) begin
      cmp("R2-R7 cause", {2'b0, cause}, {2'b0, m_cause});
      cmp("R10 status pm", {7'b0, sts_pm}, {7'b0, m_sts});
      cmp("R10 status csr", {7'b0, sts_csr}, {7'b0, m_sts});
      cmp("R11 pin", {7'b0, pme_n}, {7'b0, !(m_sts && pme_en)});
    end
  end

  always @(posedge clk) if (cyc == 60000 && !done) begin
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic hdr(input logic [47:0] da, input logic [15:0] et);
    txq.delete();
    for (int k = 0; k < 6; k++) txq.push_back(da[47-8*k -: 8]);
    for (int k = 0; k < 6; k++) txq.push_back(8'h10 + 8'(k));
    txq.push_back(et[15:8]); txq.push_back(et[7:0]);
  endtask

  task automatic pad(input int n);
    for (int k = 0; k < n; k++) txq.push_back(8'((k * 7 + 3) & 8'h7F));
  endtask

  task automatic push_mac(input int copies);
    for (int c = 0; c < copies; c++)
      for (int k = 0; k < 6; k++) txq.push_back(mac[47-8*k -: 8]);
  endtask

  task automatic send(input bit good);
    for (int k = 0; k < txq.size(); k++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = txq[k];
      rx_sof = (k == 0); rx_eof = (k == txq.size() - 1); rx_crc = good;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    @(negedge clk);
  endtask

  task automatic expect_cause(string tag, logic [5:0] exp);
    cmp(tag, {2'b0, cause}, {2'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    cmp("R1 reset cause", {2'b0, cause}, 8'h0);
    cmp("R1 reset pin", {7'b0, pme_n}, 8'h1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    hdr(mac, 16'h0800); pad(50); send(1);
    expect_cause("R2 unicast", 6'b000001);
    cmp("R10 both flags", {6'b0, sts_pm, sts_csr}, 8'h3);
    cmp("R11 pin low", {7'b0, pme_n}, 8'h0);
    do_clear();
    expect_cause("R12 clear", 6'b0);
    cmp("R12 pin released", {7'b0, pme_n}, 8'h1);

    hdr(48'h01005E000001, 16'h0800); pad(50); send(1);
    expect_cause("R3 multicast", 6'b000010);
    do_clear();

    hdr(48'hFFFFFFFFFFFF, 16'h0800); pad(50); send(1);
    expect_cause("R4 non-ARP broadcast ignored", 6'b0);
    cmp("R4 pin idle", {7'b0, pme_n}, 8'h1);
    hdr(48'hFFFFFFFFFFFF, 16'h0806); pad(50); send(1);
    expect_cause("R4 broadcast ARP", 6'b000100);
    do_clear();
    hdr(48'hFFFFFFFFFFFF, 16'h8100);
    txq.push_back(8'h00); txq.push_back(8'h05);
    txq.push_back(8'h08); txq.push_back(8'h06); pad(46); send(1);
    expect_cause("R4 VLAN ARP", 6'b000100);
    do_clear();

    hdr(mac, 16'h0800); pad(50); send(0);
    expect_cause("R8 bad CRC dropped", 6'b0);

    // magic with false start broken by 0xFF
    hdr(48'h020000000099, 16'h0842); pad(3);
    for (int k = 0; k < 6; k++) txq.push_back(8'hFF);
    push_mac(5);
    txq.push_back(8'h00); txq.push_back(8'h1B);
    txq.push_back(8'hFF);
    for (int k = 0; k < 5; k++) txq.push_back(8'hFF);
    push_mac(16); pad(4); send(1);
    expect_cause("R6 magic after FF restart", 6'b010000);
    do_clear();
    hdr(48'h020000000099, 16'h0842);
    for (int k = 0; k < 6; k++) txq.push_back(8'hFF);
    push_mac(15); pad(10); send(1);
    expect_cause("R6 fifteen copies rejected", 6'b0);

    wake_en = 6'b111111;
    hdr(48'h020000000099, 16'h0800); pad(50); send(1);
    expect_cause("R5 any frame", 6'b001000);
    do_clear();

    @(negedge clk); link = 1; repeat (2) @(negedge clk);
    expect_cause("R7 link up", 6'b100000);
    do_clear();
    @(negedge clk); link = 0; repeat (2) @(negedge clk);
    expect_cause("R7 link down", 6'b100000);
    do_clear();

    wake_en = 6'b110110;
    hdr(mac, 16'h0800); pad(50); send(1);
    expect_cause("R9 disabled source", 6'b0);

    wake_en = 6'b111111; pwr = 2'd0;
    hdr(mac, 16'h0800); pad(50); send(1);
    @(negedge clk); link = 1; repeat (2) @(negedge clk);
    expect_cause("R9 no record in D0", 6'b0);

    pwr = 2'd1; pme_en = 0;
    @(negedge clk); link = 0; repeat (2) @(negedge clk);
    cmp("R10 status with pin disabled", {6'b0, sts_pm, sts_csr}, 8'h3);
    cmp("R11 pin gated off", {7'b0, pme_n}, 8'h1);
    @(negedge clk); pme_en = 1; pwr = 2'd0;
    @(negedge clk);
    cmp("R11 pin in D0", {7'b0, pme_n}, 8'h0);
    do_clear();

    pwr = 2'd2;
    @(negedge clk); clr = 1; link = 1;
    @(negedge clk); clr = 0;
    @(negedge clk);
    expect_cause("R12 event beats clear", 6'b100000);
    cmp("R12 pin held", {7'b0, pme_n}, 8'h0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule